// File: doc/BRIEF.md
# I2C SCL Clock Divider

This block turns the system clock into the timing skeleton of an I2C controller. A prescaler divides the clock by a programmable amount to make an internal tick enable. A phase counter counts those ticks to build the SCL waveform: a low phase followed by a high phase, repeating for as long as the controller engine holds `run_i` high. The high phase is longer by a fixed number of ticks. These extra ticks cover the SCL rise time, the fall time and the internal delay. The engine uses the single-cycle fall and rise strobes to move SDA and to sample it.

Before the first SCL low phase of a transfer, the block holds SCL high for a programmable number of clock cycles. This gives SDA setup time ahead of the first bit. The divider values come in as one packed word with the prescale field in the low bits and the SCL stretch field above it. The setup delay has its own 4-bit register. Both are loaded only while the block is idle, so a running waveform never changes shape part way through.

Top module: `scl_clkgen`

## Requirements
- R1: While `run_i` is low, the block is idle. One cycle after `run_i` is low, `scl_o` is 1 and `tick_o`, `setup_o`, `scl_fall_o` and `scl_rise_o` are all 0.
- R2: While SCL is being generated, `tick_o` pulses once every CDF+1 clock cycles. The prescaler restarts at the first low phase, so the first tick falls on cycle CDF+1 of that phase.
- R3: The low phase lasts 10+4·SCGD ticks and the high phase lasts 10+4·SCGD+R_TICKS ticks, for a period of 20+8·SCGD+R_TICKS ticks. The base part is always even, so the two halves share it equally.
- R4: `scl_fall_o` is high for exactly one cycle, the first cycle in which `scl_o` is 0. `scl_rise_o` is high for exactly one cycle, the first cycle of each high phase. The two strobes are never high together.
- R5: When `run_i` rises while the block is idle, `setup_o` is high for FBS+2 cycles (FBS=4 gives 6, FBS=15 gives 17). During this delay `scl_o` stays 1 and no tick occurs. The low phase follows directly.
- R6: The clock-control word packs CDF in `cfg_i[CDF_W-1:0]` and SCGD (6 bits, 0 to 63) in `cfg_i[CDF_W+5:CDF_W]`. CDF_W is a parameter of 2 or 3.
- R7: `cfg_wr_i` and `fbs_wr_i` take effect only while the block is idle. A write while SETUP or SCL generation is active is ignored.
- R8: After reset, CDF=0, SCGD=0 and FBS=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Controller engine requests SCL generation |
| cfg_wr_i | input | 1 | Load the clock-control word |
| cfg_i | input | CDF_W+6 | Packed word: SCGD above CDF |
| fbs_wr_i | input | 1 | Load the first-bit setup value |
| fbs_i | input | 4 | First-bit setup value, delay is value+2 cycles |
| tick_o | output | 1 | Internal tick enable |
| scl_o | output | 1 | SCL level, 1 released / 0 driven low |
| scl_fall_o | output | 1 | Strobe on the first cycle of each low phase |
| scl_rise_o | output | 1 | Strobe on the first cycle of each high phase |
| setup_o | output | 1 | First-bit setup delay in progress |

## Verification
The assertions check the following on every cycle:
- the idle levels one cycle after `run_i` falls;
- the silence of SCL and tick during the setup delay;
- the exclusivity of the strobes and their agreement with the SCL level;
- the minimum spacing of ticks;
- that the configuration stays frozen while the block is not idle.

Only the bench scenarios can show the exact lengths. These are the low-phase, high-phase and setup-delay lengths in cycles and in ticks, for every prescale value and a spread of stretch and setup values. The bench also shows the reset defaults and that a write issued mid-transfer has no effect on the following transfer.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;

    localparam int SCGD_W = 6;
    localparam int FBS_W  = 4;
    localparam logic [FBS_W-1:0] FBS_RESET = 4'h4;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_LOW   = 2'd2,
        PH_HIGH  = 2'd3
    } phase_e;

endpackage

// File: rtl/scl_clkgen_cfg.sv
module scl_clkgen_cfg
    import scl_clkgen_pkg::*;
#(
    parameter int CDF_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     idle_i,
    input  logic                     cfg_wr_i,
    input  logic [CDF_W+SCGD_W-1:0]  cfg_i,
    input  logic                     fbs_wr_i,
    input  logic [FBS_W-1:0]         fbs_i,
    output logic [CDF_W-1:0]         cdf_o,
    output logic [SCGD_W-1:0]        scgd_o,
    output logic [FBS_W-1:0]         fbs_o
);

    typedef struct packed {
        logic [CDF_W-1:0]  cdf;
        logic [SCGD_W-1:0] scgd;
        logic [FBS_W-1:0]  fbs;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (idle_i && cfg_wr_i) begin
            cfg_d.cdf  = cfg_i[CDF_W-1:0];
            cfg_d.scgd = cfg_i[CDF_W+SCGD_W-1:CDF_W];
        end
        if (idle_i && fbs_wr_i) begin
            cfg_d.fbs = fbs_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{cdf: '0, scgd: '0, fbs: FBS_RESET};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cdf_o  = cfg_q.cdf;
    assign scgd_o = cfg_q.scgd;
    assign fbs_o  = cfg_q.fbs;

    // R7: nothing changes while a transfer is in progress
    a_r7_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_i |=> $stable(cfg_q));

endmodule

// File: rtl/scl_clkgen_prescale.sv
module scl_clkgen_prescale #(
    parameter int CDF_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CDF_W-1:0] cdf_i,
    output logic             tick_o
);

    logic [CDF_W-1:0] pre_d, pre_q;
    logic             wrap;

    always_comb begin
        wrap  = (pre_q == cdf_i);
        pre_d = pre_q;
        if (!en_i) begin
            pre_d = '0;
        end else if (wrap) begin
            pre_d = '0;
        end else begin
            pre_d = pre_q + CDF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    assign tick_o = en_i && wrap;

    // R2: counter never passes its reload value while enabled
    a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> (pre_q <= cdf_i));

    // R2: with a divide above one, ticks never come back to back
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tick_o && cdf_i != '0) |=> !tick_o);

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
    import scl_clkgen_pkg::*;
#(
    parameter int CDF_W   = 3,
    parameter int R_TICKS = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run_i,
    input  logic                    cfg_wr_i,
    input  logic [CDF_W+SCGD_W-1:0] cfg_i,
    input  logic                    fbs_wr_i,
    input  logic [FBS_W-1:0]        fbs_i,
    output logic                    tick_o,
    output logic                    scl_o,
    output logic                    scl_fall_o,
    output logic                    scl_rise_o,
    output logic                    setup_o
);

    localparam int HALF_MAX = 10 + 4 * ((1 << SCGD_W) - 1);
    localparam int PCNT_W   = $clog2(HALF_MAX + R_TICKS + 1);
    localparam int SCNT_W   = FBS_W + 1;

    typedef struct packed {
        phase_e            phase;
        logic [PCNT_W-1:0] pcnt;
        logic [SCNT_W-1:0] scnt;
        logic              fall;
        logic              rise;
    } st_t;

    st_t st_d, st_q;

    logic [CDF_W-1:0]  cdf;
    logic [SCGD_W-1:0] scgd;
    logic [FBS_W-1:0]  fbs;
    logic              idle;
    logic              gen_en;
    logic              tick;
    logic [PCNT_W-1:0] half;
    logic [PCNT_W-1:0] low_load;
    logic [PCNT_W-1:0] high_load;

    assign idle   = (st_q.phase == PH_IDLE);
    assign gen_en = (st_q.phase == PH_LOW) || (st_q.phase == PH_HIGH);

    scl_clkgen_cfg #(.CDF_W(CDF_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle_i   (idle),
        .cfg_wr_i (cfg_wr_i),
        .cfg_i    (cfg_i),
        .fbs_wr_i (fbs_wr_i),
        .fbs_i    (fbs_i),
        .cdf_o    (cdf),
        .scgd_o   (scgd),
        .fbs_o    (fbs)
    );

    scl_clkgen_prescale #(.CDF_W(CDF_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (gen_en),
        .cdf_i  (cdf),
        .tick_o (tick)
    );

    always_comb begin
        half      = PCNT_W'(10) + (PCNT_W'(scgd) << 2);
        low_load  = half - PCNT_W'(1);
        high_load = half + PCNT_W'(R_TICKS) - PCNT_W'(1);
    end

    always_comb begin
        st_d      = st_q;
        st_d.fall = 1'b0;
        st_d.rise = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                st_d.phase = PH_SETUP;
                st_d.scnt  = {1'b0, fbs} + SCNT_W'(1);
            end
            PH_SETUP: begin
                if (st_q.scnt == '0) begin
                    st_d.phase = PH_LOW;
                    st_d.pcnt  = low_load;
                    st_d.fall  = 1'b1;
                end else begin
                    st_d.scnt = st_q.scnt - SCNT_W'(1);
                end
            end
            PH_LOW: begin
                if (tick) begin
                    if (st_q.pcnt == '0) begin
                        st_d.phase = PH_HIGH;
                        st_d.pcnt  = high_load;
                        st_d.rise  = 1'b1;
                    end else begin
                        st_d.pcnt = st_q.pcnt - PCNT_W'(1);
                    end
                end
            end
            PH_HIGH: begin
                if (tick) begin
                    if (st_q.pcnt == '0) begin
                        st_d.phase = PH_LOW;
                        st_d.pcnt  = low_load;
                        st_d.fall  = 1'b1;
                    end else begin
                        st_d.pcnt = st_q.pcnt - PCNT_W'(1);
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
        if (!run_i) begin
            st_d = '{phase: PH_IDLE, pcnt: '0, scnt: '0, fall: 1'b0, rise: 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, pcnt: '0, scnt: '0, fall: 1'b0, rise: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o     = tick;
    assign scl_o      = (st_q.phase != PH_LOW);
    assign scl_fall_o = st_q.fall;
    assign scl_rise_o = st_q.rise;
    assign setup_o    = (st_q.phase == PH_SETUP);

    // R1: dropping run returns to the idle levels on the next cycle
    a_r1_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (scl_o && !tick_o && !setup_o && !scl_fall_o && !scl_rise_o));

    // R5: setup delay keeps SCL released and the tick silent
    a_r5_setup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        setup_o |-> (scl_o && !tick_o));

    // R4: strobes are exclusive
    a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_fall_o && scl_rise_o));

    // R4: fall strobe only with SCL low, rise strobe only with SCL high
    a_r4_fall_level: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall_o |-> !scl_o);

    a_r4_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise_o |-> scl_o);

    // R4: a strobe is one cycle wide
    a_r4_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall_o |=> !scl_fall_o);

endmodule

// File: tb/scl_clkgen_bench.sv
`timescale 1ns/1ps
module scl_clkgen_bench;

    localparam int CDF_W = 3;
    localparam int R_T   = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             run;
    logic             cfg_wr;
    logic [CDF_W+5:0] cfg;
    logic             fbs_wr;
    logic [3:0]       fbs;
    logic             tick_o, scl_o, fall_o, rise_o, setup_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    scl_clkgen #(.CDF_W(CDF_W), .R_TICKS(R_T)) u_scl_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .cfg_wr_i   (cfg_wr),
        .cfg_i      (cfg),
        .fbs_wr_i   (fbs_wr),
        .fbs_i      (fbs),
        .tick_o     (tick_o),
        .scl_o      (scl_o),
        .scl_fall_o (fall_o),
        .scl_rise_o (rise_o),
        .setup_o    (setup_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Measures one transfer: setup delay, one low phase, one high phase.
    task automatic run_case(input int cdf, input int sg, input int fb,
                            input bit wr, input bit inject);
        int n, tk, st;
        int half;
        half = 10 + 4 * sg;
        @(negedge clk);
        if (wr) begin
            cfg_wr = 1'b1;
            cfg    = {6'(sg), 3'(cdf)};
            fbs_wr = 1'b1;
            fbs    = 4'(fb);
            @(negedge clk);
            cfg_wr = 1'b0;
            fbs_wr = 1'b0;
        end
        run = 1'b1;
        n = 0;
        @(negedge clk);
        while (setup_o && n < 100) begin
            if (inject && n == 0) begin
                // R7: writes while busy must be ignored
                cfg_wr = 1'b1; cfg = '0; fbs_wr = 1'b1; fbs = 4'd15;
            end else begin
                cfg_wr = 1'b0; fbs_wr = 1'b0;
            end
            if (tick_o || !scl_o) check(1'b0, "R5 quiet setup", 1, 0);
            n++;
            @(negedge clk);
        end
        cfg_wr = 1'b0; fbs_wr = 1'b0;
        check(n == fb + 2, "R5 setup cycles", n, fb + 2);
        check(fall_o && !scl_o, "R4 fall strobe at low start", int'(fall_o), 1);
        n = 0; tk = 0; st = 0;
        while (!scl_o && n < 5000) begin
            n++;
            if (tick_o) tk++;
            if (fall_o) st++;
            @(negedge clk);
        end
        check(n == half * (cdf + 1), "R3 low cycles", n, half * (cdf + 1));
        check(tk == half, "R2 ticks in low", tk, half);
        check(st == 1, "R4 single fall strobe", st, 1);
        check(rise_o, "R4 rise strobe at high start", int'(rise_o), 1);
        n = 0; tk = 0; st = 0;
        while (scl_o && n < 5000) begin
            n++;
            if (tick_o) tk++;
            if (rise_o) st++;
            @(negedge clk);
        end
        check(n == (half + R_T) * (cdf + 1), "R3 high cycles", n, (half + R_T) * (cdf + 1));
        check(tk == half + R_T, "R2 ticks in high", tk, half + R_T);
        check(st == 1, "R4 single rise strobe", st, 1);
        check(fall_o, "R4 fall strobe next period", int'(fall_o), 1);
        run = 1'b0;
        @(negedge clk);
        check(scl_o && !tick_o && !setup_o && !fall_o && !rise_o, "R1 idle after stop",
              int'({scl_o, tick_o, setup_o}), 4);
    endtask

    initial begin
        int sg_tab[4];
        sg_tab = '{0, 1, 7, 63};
        rst_n = 1'b0; run = 1'b0; cfg_wr = 1'b0; cfg = '0; fbs_wr = 1'b0; fbs = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(scl_o && !tick_o && !setup_o && !fall_o && !rise_o, "R1 reset outputs",
              int'({scl_o, tick_o, setup_o}), 4);
        // R8: defaults CDF=0, SCGD=0, FBS=4 without any write
        run_case(0, 0, 4, 1'b0, 1'b0);
        // R6 packing, R2/R3/R5 sweep
        for (int c = 0; c < 8; c++) begin
            for (int s = 0; s < 4; s++) begin
                run_case(c, sg_tab[s], (c * 4 + s) % 16, 1'b1, 1'b0);
            end
        end
        // R7: busy write ignored, next transfer keeps old values
        run_case(2, 1, 9, 1'b1, 1'b1);
        run_case(2, 1, 9, 1'b0, 1'b0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule